// File: doc/BRIEF.md
# First-Arrival Detector

This block decides which of two asynchronous signals makes its low-to-high transition first. Each signal passes through its own chain of flip-flops clocked by the system clock. Only after that chain does any logic look at it. The ordering decision then uses plain synchronous logic, so neither monitored signal drives a clock pin. The decision resolves to one clock period: two edges that land in the same period count as simultaneous.

The block is used one measurement at a time. Software or a controlling state machine pulses the arm input while both signals are low. The block then waits for the first cycle in which either synchronized signal is seen rising. In that cycle it latches a 2-bit order code and a winner bit, and it raises a valid pulse for one cycle. When both signals rise in the same cycle, the winner comes from a stored preference bit, and that bit flips after every such tie. Successive ties therefore alternate between the two signals. If arm arrives while either synchronized signal is already high, the block reports an arming error and takes no measurement.

Top module: `arrival_order_detector`

## Requirements
- R1: A rise on a monitored input that is first sampled high at clock edge n causes valid_o to be high after edge n+SYNC_STAGES and not before, provided the block is armed.
- R2: When signal A is seen rising strictly before signal B, order_o reads 2'b01 (bit 0 = A rose, bit 1 = B rose) and winner_o reads 0.
- R3: When signal B is seen rising strictly before signal A, order_o reads 2'b10 and winner_o reads 1.
- R4: When both signals are first seen rising in the same cycle, order_o reads 2'b11 and winner_o equals the preference bit. The preference bit starts at 0 (A) and inverts after every tie.
- R5: A result that is not a tie leaves the preference bit unchanged.
- R6: valid_o is high for exactly one cycle per measurement. order_o and winner_o hold their value until the next result, and later input changes have no effect until the block is re-armed.
- R7: Pulsing arm_i while either synchronized input is high raises arm_err_o for one cycle, produces no valid_o, and leaves the block unarmed.
- R8: While unarmed, rising inputs produce no valid_o. While armed, a further arm_i has no effect.
- R9: Asserting rst_ni low clears valid_o, order_o, winner_o and arm_err_o, and resets the preference bit to 0.
- R10: Two rising edges inside the same clock period, whatever their spacing within it, give a tie.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Starts a measurement when both inputs are low |
| sig_a_i | input | 1 | Asynchronous monitored signal A |
| sig_b_i | input | 1 | Asynchronous monitored signal B |
| valid_o | output | 1 | One-cycle pulse when a result is latched |
| order_o | output | 2 | Order code: 01 A first, 10 B first, 11 tie |
| winner_o | output | 1 | Winning signal: 0 = A, 1 = B |
| arm_err_o | output | 1 | One-cycle pulse when arming is refused |

## Verification
A corrupted preference bit appears at the ports only at the next tie, where winner_o breaks the expected alternation. A bad synchronizer depth or a bad edge register shows up as valid_o arriving a cycle early or late relative to the input edge. It can also show up as a measurement that never completes. A result register that is not frozen after a measurement becomes visible the moment the losing input rises: order_o changes, or a second valid pulse appears, within SYNC_STAGES+1 cycles. The bench compares every output against a behavioural model on every clock, so each of these faults is caught in the first cycle it reaches the outputs.

// File: rtl/arrival_order_pkg.sv
`timescale 1ns/1ps
package arrival_order_pkg;
  // bit 0: A rose, bit 1: B rose
  typedef enum logic [1:0] {
    ORDER_NONE = 2'b00,
    ORDER_A    = 2'b01,
    ORDER_B    = 2'b10,
    ORDER_TIE  = 2'b11
  } order_e;

  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_ARMED = 1'b1
  } phase_e;

  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/aod_sync_chain.sv
`timescale 1ns/1ps
module aod_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  if (STAGES < 2) begin : g_bad_depth
    $error("aod_sync_chain: STAGES must be at least 2");
  end

  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/aod_edge_detect.sv
`timescale 1ns/1ps
module aod_edge_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/aod_arbiter_core.sv
`timescale 1ns/1ps
module aod_arbiter_core
  import arrival_order_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [NUM_CH-1:0] level_i,
  input  logic [NUM_CH-1:0] rise_i,
  output logic              valid_o,
  output order_e            order_o,
  output logic              winner_o,
  output logic              arm_err_o
);
  phase_e phase_q;
  logic   pref_q;
  logic   valid_q, winner_q, err_q;
  order_e order_q;

  logic   hit, tie, any_high;
  order_e code;

  always_comb begin
    hit      = |rise_i;
    tie      = &rise_i;
    any_high = |level_i;
    code     = order_e'(rise_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      pref_q   <= 1'b0;
      valid_q  <= 1'b0;
      order_q  <= ORDER_NONE;
      winner_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (arm_i) begin
            if (any_high) err_q   <= 1'b1;
            else          phase_q <= PH_ARMED;
          end
        end
        PH_ARMED: begin
          if (hit) begin
            valid_q <= 1'b1;
            order_q <= code;
            phase_q <= PH_IDLE;
            if (tie) begin
              winner_q <= pref_q;
              pref_q   <= ~pref_q;
            end else begin
              winner_q <= rise_i[1];
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign valid_o   = valid_q;
  assign order_o   = order_q;
  assign winner_o  = winner_q;
  assign arm_err_o = err_q;

  assert_tie_flips_pref_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && order_q == ORDER_TIE) |-> (pref_q != $past(pref_q)));

  assert_nontie_keeps_pref_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && order_q != ORDER_TIE) |-> (pref_q == $past(pref_q)));

  assert_valid_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  assert_err_no_result_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (!valid_q && phase_q == PH_IDLE));

  assert_b_first_winner_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && order_q == ORDER_B) |-> winner_q);

  assert_a_first_winner_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && order_q == ORDER_A) |-> !winner_q);
endmodule

// File: rtl/arrival_order_detector.sv
`timescale 1ns/1ps
module arrival_order_detector
  import arrival_order_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_i,
  input  logic       sig_a_i,
  input  logic       sig_b_i,
  output logic       valid_o,
  output logic [1:0] order_o,
  output logic       winner_o,
  output logic       arm_err_o
);
  logic [NUM_CH-1:0] raw, lvl, rise;
  order_e            order;

  assign raw = {sig_b_i, sig_a_i};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    aod_sync_chain #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(raw[c]),
      .sync_o (lvl[c])
    );
    aod_edge_detect i_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .level_i(lvl[c]),
      .rise_o (rise[c])
    );
  end

  aod_arbiter_core i_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm_i),
    .level_i  (lvl),
    .rise_i   (rise),
    .valid_o  (valid_o),
    .order_o  (order),
    .winner_o (winner_o),
    .arm_err_o(arm_err_o)
  );

  assign order_o = order;

  assert_result_nonempty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (order_o != 2'b00));
endmodule

// File: tb/test_arrival_order_detector.sv
`timescale 1ns/1ps
module test_arrival_order_detector;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, a = 1'b0, b = 1'b0;
  logic valid, winner, arm_err;
  logic [1:0] order;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  arrival_order_detector #(.SYNC_STAGES(S)) i_arrival_order_detector (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .sig_a_i(a), .sig_b_i(b),
    .valid_o(valid), .order_o(order), .winner_o(winner), .arm_err_o(arm_err)
  );

  // behavioural reference model
  bit qa[$], qb[$];
  bit m_armed, m_pref, m_valid, m_win, m_err;
  bit [1:0] m_res;
  bit sa, pa, sb, pb, ra, rb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qa = {}; qb = {};
      for (int i = 0; i <= S; i++) begin qa.push_back(1'b0); qb.push_back(1'b0); end
      m_armed = 0; m_pref = 0; m_valid = 0; m_win = 0; m_err = 0; m_res = 2'b00;
    end else begin
      sa = qa[S-1]; pa = qa[S]; sb = qb[S-1]; pb = qb[S];
      ra = sa && !pa; rb = sb && !pb;
      m_valid = 0; m_err = 0;
      if (!m_armed) begin
        if (arm) begin
          if (sa || sb) m_err = 1; else m_armed = 1;
        end
      end else if (ra || rb) begin
        m_valid = 1;
        m_res = {rb, ra};
        if (ra && rb) begin m_win = m_pref; m_pref = !m_pref; end
        else m_win = rb;
        m_armed = 0;
      end
      qa.push_front(a); void'(qa.pop_back());
      qb.push_front(b); void'(qb.pop_back());
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(valid === m_valid, "R6 valid_o", valid, m_valid);
      check(order === m_res, "R2 R3 R4 order_o", order, m_res);
      check(winner === m_win, "R4 winner_o", winner, m_win);
      check(arm_err === m_err, "R7 arm_err_o", arm_err, m_err);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic go_idle_low;
    a = 0; b = 0; arm = 0;
    tick(S + 3);
  endtask

  task automatic do_arm;
    arm = 1; tick(1); arm = 0;
  endtask

  task automatic expect_result(input string req, input int ord, input int win);
    check(valid === 1'b1, req, valid, 1);
    check(order === ord[1:0], req, order, ord);
    check(winner === win[0], req, winner, win);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    // R9 reset state
    check(valid === 0 && order === 2'b00 && winner === 0 && arm_err === 0,
          "R9 reset outputs", {valid, order, winner, arm_err}, 0);
    rst_n = 1;
    tick(2);

    // R1 latency and R2 A first
    do_arm();
    a = 1;
    tick(S);
    check(valid === 0, "R1 early valid", valid, 0);
    tick(1);
    expect_result("R1 R2 A first", 1, 0);
    b = 1;
    tick(1);
    check(valid === 0, "R6 single pulse", valid, 0);
    tick(S + 2);
    check(order === 2'b01 && valid === 0, "R6 held after loser", order, 1);

    // R3 B first
    go_idle_low();
    do_arm();
    b = 1;
    tick(S + 1);
    expect_result("R3 B first", 2, 1);
    a = 1;
    tick(S + 2);

    // R4 ties alternate from A
    go_idle_low();
    do_arm();
    a = 1; b = 1;
    tick(S + 1);
    expect_result("R4 first tie", 3, 0);
    go_idle_low();
    do_arm();
    a = 1; b = 1;
    tick(S + 1);
    expect_result("R4 second tie", 3, 1);

    // R5 non-tie keeps preference
    go_idle_low();
    do_arm();
    a = 1; tick(1); b = 1;
    tick(S);
    expect_result("R5 A before tie", 1, 0);
    go_idle_low();
    do_arm();
    a = 1; b = 1;
    tick(S + 1);
    expect_result("R5 tie after non-tie", 3, 0);

    // R10 sub-cycle spacing is a tie (pref now 1)
    go_idle_low();
    do_arm();
    @(posedge clk); #1 a = 1;
    @(negedge clk); b = 1;
    tick(S + 1);
    expect_result("R10 same period", 3, 1);

    // R7 arming while input high
    go_idle_low();
    a = 1;
    tick(S + 2);
    do_arm();
    check(arm_err === 1 && valid === 0, "R7 arm error", arm_err, 1);
    tick(1);
    check(arm_err === 0, "R7 error pulse", arm_err, 0);
    // R8 unarmed: rising input produces nothing
    b = 1;
    tick(S + 3);
    check(valid === 0 && order === 2'b11, "R8 unarmed ignores", order, 3);

    // R8 re-arm while armed has no effect
    go_idle_low();
    do_arm();
    arm = 1; tick(3); arm = 0;
    check(arm_err === 0 && valid === 0, "R8 arm while armed", arm_err, 0);
    b = 1;
    tick(S + 1);
    expect_result("R8 still armed", 2, 1);

    // R9 reset restores preference to A
    go_idle_low();
    rst_n = 0;
    tick(2);
    check(valid === 0 && order === 2'b00 && winner === 0, "R9 mid reset", order, 0);
    rst_n = 1;
    tick(2);
    do_arm();
    a = 1; b = 1;
    tick(S + 1);
    expect_result("R9 R4 tie after reset", 3, 0);
    tick(3);
    finish_run();
  end
endmodule